// File: doc/BRIEF.md
# Device Controller Global Control and Status Registers

This block holds the global control state of a USB device controller behind a plain 32-bit register bus. Software never edits a feature with a read-modify-write. Each feature owns two strobe bits in the configuration word: one turns the feature on and the other turns it off. A single write can change any set of features and leave the rest alone. The latched feature states drive the link logic through `feat_o`, and most of them can also be read in the status word.

The command word carries a 7-bit device address. That address is taken only when the commit bit of the same write is 1. The status word also shows a sticky flag that rises once a nonzero address has been committed.

Link-side event pulses are captured in an interrupt status register and cleared by writing 1. A matching enable register gates them onto a single interrupt line.

Register offsets are byte addresses:

| Offset | Register |
|---|---|
| 0x00 | configuration |
| 0x04 | status |
| 0x08 | command |
| 0x14 | interrupt enable |
| 0x18 | interrupt status |

Other offsets read 0 and ignore writes. A write takes effect at the clock edge where `bus_wr` is 1. Reads are combinational from the registered state.

Top module: `usbdev_ctrl_regs`

## Requirements
- R1: A configuration write turns features on and off with these strobe bits. The same writes are also reflected in the status word at the listed positions.

  | Feature | `feat_o` bit | On bit | Off bit | Status bit |
  |---|---|---|---|---|
  | device enable | 0 | 14 | 15 | 14 |
  | L1 entry | 1 | 16 | 17 | 16 |
  | U1 entry | 2 | 24 | 25 | 24 |
  | U2 entry | 3 | 26 | 27 | 25 |
  | DMA clock-off | 4 | 10 | 11 | 30 |

- R2: A configuration write with both bits of a pair at 1, or both at 0, leaves that feature unchanged.
- R3: After reset all features are 0, the address is 0 and the status word reads 0x0000_0100. Bit 8 of the status word always reads 1 (USB2 clock-off), and DMA clock-off reads 0.
- R4: A command write stores bits 7:1 as the device address only when bit 0 of the same write is 1; otherwise the address is kept. The command word reads the address back in bits 7:1 with bit 0 as 0.
- R5: Status bit 15 becomes 1 after a nonzero address is committed and stays 1 until reset. Committing address 0 does not set it.
- R6: The configuration word always reads 0.
- R7: An event pulse on `link_evt` sets the interrupt status bit at the same position. Only positions 0, 1, 2, 3, 10, 16, 17 and 18 exist. The enable register holds the same positions, and every other bit of either register reads 0.
- R8: Writing 1 to an interrupt status bit clears it. An event arriving in the same cycle as the clear wins, and the bit stays 1.
- R9: `irq_o` is 1 exactly when some interrupt status bit and its enable bit are both 1.
- R10: Force full speed (`feat_o` bit 5) is set by configuration bit 13 and cleared by bit 12. If both bits are 1, it is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | byte address of the access |
| bus_wr | input | 1 | write strobe, one cycle per write |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for `bus_addr` |
| link_evt | input | 32 | one-cycle event pulses from the link logic |
| feat_o | output | 6 | latched feature states, bit order as in R1 and R10 |
| fn_addr_o | output | 7 | committed device address |
| irq_o | output | 1 | interrupt request |

## Verification
On every cycle the assertions check the following:
- a device-enable strobe takes effect;
- a contradictory strobe pair holds the feature;
- the address stays unchanged without a commit;
- the addressed flag is sticky;
- an event always beats a same-cycle clear;
- an enabled event raises the interrupt.

Only the bench scenarios show the full read encodings of each word, including the exact status bit positions, the zero read of the configuration word and the masking of unimplemented interrupt bits. The same holds for multi-feature writes, the rule that committing address zero leaves the addressed flag clear, and the interaction between enable changes and pending status.

// File: rtl/usbdev_regs_pkg.sv
package usbdev_regs_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned NFEAT  = 6;
    localparam int unsigned FADR_W = 7;

    // byte offsets of the registers
    localparam logic [7:0] OFS_CONF = 8'h00;
    localparam logic [7:0] OFS_STS  = 8'h04;
    localparam logic [7:0] OFS_CMD  = 8'h08;
    localparam logic [7:0] OFS_IEN  = 8'h14;
    localparam logic [7:0] OFS_ISTS = 8'h18;

    // per-feature strobe positions, status position and reset value
    // order: device enable, L1, U1, U2, DMA clock-off, force full speed
    localparam int unsigned ON_POS  [NFEAT] = '{14, 16, 24, 26, 10, 13};
    localparam int unsigned OFF_POS [NFEAT] = '{15, 17, 25, 27, 11, 12};
    localparam int unsigned STS_POS [NFEAT] = '{14, 16, 24, 25, 30, 0};
    localparam logic [NFEAT-1:0] STS_SHOWN = 6'b01_1111;
    localparam logic [NFEAT-1:0] FEAT_RST  = 6'b00_0000;

    localparam int unsigned STS_U2CLK_POS  = 8;
    localparam int unsigned STS_ADDRD_POS  = 15;
    localparam int unsigned CMD_COMMIT_POS = 0;

    // interrupt positions that exist
    localparam logic [DATA_W-1:0] IRQ_IMPL = 32'h0007_040F;

    typedef struct packed {
        logic [FADR_W-1:0] fn_addr;
        logic              addressed;
    } cmd_state_t;

endpackage

// File: rtl/usbdev_strobe_cell.sv
module usbdev_strobe_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_stb,
    input  logic off_stb,
    output logic state
);

    logic state_d;
    logic state_q;

    always_comb begin
        state_d = state_q;
        if (on_stb && !off_stb) begin
            state_d = 1'b1;
        end else if (off_stb && !on_stb) begin
            state_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_VAL;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/usbdev_irq_bank.sv
module usbdev_irq_bank #(
    parameter int unsigned     W    = 32,
    parameter logic [W-1:0]    IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ien_we,
    input  logic         ists_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] evt,
    output logic [W-1:0] ien,
    output logic [W-1:0] ists,
    output logic         irq
);

    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] st;
    } bank_t;

    bank_t bk_d;
    bank_t bk_q;

    always_comb begin
        bk_d = bk_q;
        if (ien_we) begin
            bk_d.en = wdata & IMPL;
        end
        if (ists_we) begin
            bk_d.st = bk_q.st & ~wdata;
        end
        // a new event overrides a clear in the same cycle
        bk_d.st = (bk_d.st | evt) & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign ien  = bk_q.en;
    assign ists = bk_q.st;
    assign irq  = |(bk_q.st & bk_q.en);

endmodule

// File: rtl/usbdev_ctrl_regs.sv
module usbdev_ctrl_regs
    import usbdev_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       link_evt,
    output logic [5:0]        feat_o,
    output logic [6:0]        fn_addr_o,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_CONF = ADDR_W'(OFS_CONF);
    localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);
    localparam logic [ADDR_W-1:0] A_ISTS = ADDR_W'(OFS_ISTS);

    logic conf_we;
    logic cmd_we;
    logic ien_we;
    logic ists_we;

    assign conf_we = bus_wr && (bus_addr == A_CONF);
    assign cmd_we  = bus_wr && (bus_addr == A_CMD);
    assign ien_we  = bus_wr && (bus_addr == A_IEN);
    assign ists_we = bus_wr && (bus_addr == A_ISTS);

    // feature strobe cells
    logic [NFEAT-1:0] feat_w;

    for (genvar g = 0; g < NFEAT; g++) begin : g_feat
        usbdev_strobe_cell #(
            .RST_VAL (FEAT_RST[g])
        ) i_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .on_stb  (conf_we && bus_wdata[ON_POS[g]]),
            .off_stb (conf_we && bus_wdata[OFF_POS[g]]),
            .state   (feat_w[g])
        );
    end

    // interrupt bank
    logic [31:0] ien_w;
    logic [31:0] ists_w;
    logic        irq_w;

    usbdev_irq_bank #(
        .W    (DATA_W),
        .IMPL (IRQ_IMPL)
    ) i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ien_we  (ien_we),
        .ists_we (ists_we),
        .wdata   (bus_wdata),
        .evt     (link_evt),
        .ien     (ien_w),
        .ists    (ists_w),
        .irq     (irq_w)
    );

    // command word state
    cmd_state_t st_d;
    cmd_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_we && bus_wdata[CMD_COMMIT_POS]) begin
            st_d.fn_addr = bus_wdata[FADR_W:1];
            if (bus_wdata[FADR_W:1] != '0) begin
                st_d.addressed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // status word assembly
    logic [31:0] sts_word;

    always_comb begin
        sts_word = '0;
        sts_word[STS_U2CLK_POS] = 1'b1;
        sts_word[STS_ADDRD_POS] = st_q.addressed;
        for (int i = 0; i < NFEAT; i++) begin
            if (STS_SHOWN[i]) begin
                sts_word[STS_POS[i]] = feat_w[i];
            end
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_STS:   bus_rdata = sts_word;
            A_CMD:   bus_rdata = {24'h0, st_q.fn_addr, 1'b0};
            A_IEN:   bus_rdata = ien_w;
            A_ISTS:  bus_rdata = ists_w;
            default: bus_rdata = '0;
        endcase
    end

    assign feat_o    = feat_w;
    assign fn_addr_o = st_q.fn_addr;
    assign irq_o     = irq_w;

endmodule

// File: rtl/usbdev_ctrl_regs_chk.sv
module usbdev_ctrl_regs_chk
    import usbdev_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       link_evt,
    input logic [5:0]        feat_o,
    input logic [6:0]        fn_addr_o,
    input logic              irq_o,
    input logic [31:0]       ists,
    input logic [31:0]       ien,
    input logic              addressed
);

    logic conf_wr;
    logic cmd_commit;
    logic ien_wr;

    assign conf_wr    = bus_wr && (bus_addr == ADDR_W'(OFS_CONF));
    assign cmd_commit = bus_wr && (bus_addr == ADDR_W'(OFS_CMD)) && bus_wdata[0];
    assign ien_wr     = bus_wr && (bus_addr == ADDR_W'(OFS_IEN));

    a_r1_dev_on: assert property (@(posedge clk) disable iff (!rst_n)
        conf_wr && bus_wdata[14] && !bus_wdata[15] |=> feat_o[0]);

    a_r2_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
        conf_wr && bus_wdata[14] && bus_wdata[15] |=> $stable(feat_o[0]));

    a_r4_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_commit |=> $stable(fn_addr_o));

    a_r5_addressed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        addressed |=> addressed);

    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        link_evt[0] |=> ists[0]);

    a_r9_enabled_event_irq: assert property (@(posedge clk) disable iff (!rst_n)
        link_evt[10] && ien[10] && !ien_wr |=> irq_o);

endmodule

bind usbdev_ctrl_regs usbdev_ctrl_regs_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .link_evt  (link_evt),
    .feat_o    (feat_o),
    .fn_addr_o (fn_addr_o),
    .irq_o     (irq_o),
    .ists      (ists_w),
    .ien       (ien_w),
    .addressed (st_q.addressed)
);

// File: tb/test_usbdev_ctrl_regs.sv
module test_usbdev_ctrl_regs;

    localparam logic [7:0] A_CONF = 8'h00;
    localparam logic [7:0] A_STS  = 8'h04;
    localparam logic [7:0] A_CMD  = 8'h08;
    localparam logic [7:0] A_IEN  = 8'h14;
    localparam logic [7:0] A_ISTS = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] link_evt = '0;
    logic [5:0]  feat_o;
    logic [6:0]  fn_addr_o;
    logic        irq_o;

    always #5 clk = ~clk;

    usbdev_ctrl_regs i_usbdev_ctrl_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .link_evt  (link_evt),
        .feat_o    (feat_o),
        .fn_addr_o (fn_addr_o),
        .irq_o     (irq_o)
    );

    // kind: 0 read data, 1 irq, 2 features, 3 address output
    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    // monitor: compares expected items against outputs away from the edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = bus_rdata;
                    1:       act = {31'h0, irq_o};
                    2:       act = {26'h0, feat_o};
                    default: act = {25'h0, fn_addr_o};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        if (kind == 0) bus_addr = a;
        it.kind = kind;
        it.exp  = e;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk);
        #1;
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic evt(input logic [31:0] v);
        @(posedge clk);
        #1;
        link_evt = v;
        @(posedge clk);
        #1;
        link_evt = '0;
    endtask

    task automatic evt_wr(input logic [31:0] v, input logic [7:0] a, input logic [31:0] d);
        @(posedge clk);
        #1;
        link_evt  = v;
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        link_evt = '0;
        bus_wr   = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R3 reset state
        push(0, A_STS, 32'h0000_0100, "R3 status after reset");
        push(0, A_CMD, 32'h0, "R3 command after reset");
        push(2, 0, 32'h0, "R3 features after reset");
        push(1, 0, 32'h0, "R3 irq after reset");

        // R1 strobes
        wr(A_CONF, 32'h0000_4000);
        push(2, 0, 32'h01, "R1 device enable");
        push(0, A_STS, 32'h0000_4100, "R1 status device enable");
        wr(A_CONF, (32'h1 << 16) | (32'h1 << 24) | (32'h1 << 26) | (32'h1 << 10));
        push(2, 0, 32'h1F, "R1 multi enable");
        push(0, A_STS, 32'h4301_4100, "R1 status multi enable");

        // R2 contradictory pair
        wr(A_CONF, (32'h1 << 14) | (32'h1 << 15));
        push(2, 0, 32'h1F, "R2 both strobes hold");
        wr(A_CONF, (32'h1 << 15) | (32'h1 << 25));
        push(2, 0, 32'h1A, "R1 disable device and U1");
        push(0, A_STS, 32'h4201_0100, "R1 status after disable");

        // R6 config reads zero
        push(0, A_CONF, 32'h0, "R6 config reads zero");

        // R10 force full speed
        wr(A_CONF, 32'h1 << 13);
        push(2, 0, 32'h3A, "R10 force fs set");
        wr(A_CONF, (32'h1 << 13) | (32'h1 << 12));
        push(2, 0, 32'h3A, "R10 both hold");
        wr(A_CONF, 32'h1 << 12);
        push(2, 0, 32'h1A, "R10 force fs clear");

        // R4 / R5 address
        wr(A_CMD, 32'h0000_004A);
        push(3, 0, 32'h0, "R4 no commit keeps address");
        wr(A_CMD, 32'h0000_0001);
        push(0, A_STS, 32'h4201_0100, "R5 zero address not addressed");
        wr(A_CMD, 32'h0000_004B);
        push(3, 0, 32'h25, "R4 committed address");
        push(0, A_CMD, 32'h0000_004A, "R4 command readback");
        push(0, A_STS, 32'h4201_8100, "R5 addressed set");
        wr(A_CMD, 32'h0000_0030);
        push(3, 0, 32'h25, "R4 uncommitted write ignored");
        wr(A_CMD, 32'h0000_0001);
        push(3, 0, 32'h0, "R4 commit zero");
        push(0, A_STS, 32'h4201_8100, "R5 addressed sticky");

        // R7 capture and masking
        wr(A_IEN, 32'hFFFF_FFFF);
        push(0, A_IEN, 32'h0007_040F, "R7 enable mask");
        evt(32'hFFFF_FFFF);
        push(0, A_ISTS, 32'h0007_040F, "R7 status mask");
        push(1, 0, 32'h1, "R9 irq with enabled status");

        // R8 clear and priority
        wr(A_ISTS, 32'h0000_000F);
        push(0, A_ISTS, 32'h0007_0400, "R8 w1c");
        evt_wr(32'h0001_0000, A_ISTS, 32'h0001_0000);
        push(0, A_ISTS, 32'h0007_0400, "R8 event beats clear");
        wr(A_ISTS, 32'hFFFF_FFFF);
        push(0, A_ISTS, 32'h0, "R8 clear all");
        push(1, 0, 32'h0, "R9 irq low after clear");

        // R9 gating
        wr(A_IEN, 32'h0);
        evt(32'h0000_0004);
        push(0, A_ISTS, 32'h0000_0004, "R7 event captured while disabled");
        push(1, 0, 32'h0, "R9 disabled no irq");
        wr(A_IEN, 32'h0000_0004);
        push(1, 0, 32'h1, "R9 enable raises irq");
        wr(A_IEN, 32'h0000_0001);
        push(1, 0, 32'h0, "R9 other enable no irq");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule